// File: doc/BRIEF.md
# Flyback LED Controller Fault Supervisor

This block decides when a primary-side LED flyback controller must stop switching its power transistor. Analog comparators and a temperature sensor outside the block deliver one-bit flags; a one-cycle `smp_stb` pulse marks the end of each switching cycle, and the flags that belong to that cycle are valid at that pulse. From these flags the block drives a gate-inhibit output. It also selects the low or high cycle-by-cycle current-limit level, and it reports a fault-cause code for test.

Faults are qualified in different ways. A collapsed output (shorted LED string) must be seen on a run of consecutive cycle samples. This check is masked while a startup blanking input is high. A shorted sense resistor is judged in one of two ways, chosen by the control mode. In current mode only the very first cycle after a restart counts. In voltage mode the check applies only while line voltage is above 60 % of its peak. Over-current and supply over-voltage act in the cycle they occur. Over-temperature has its own hysteresis and releases the gate once the die has cooled. Every other fault is held in a latch that only the supply-undervoltage flag clears. The controller therefore always recovers through a power-down and re-start cycle, with no permanent lock-out.

Top module: `fault_supervisor`

## Requirements
- R1: After synchronous reset `gate_inh` is 0, `cl_low_sel` is 0 and `fault_code` is 0 (no fault).
- R2: On each clock with `smp_stb` high, `cl_low_sel` takes the value of `vs_below_lo` (1 = 0.2 V limit, 0 = 1.0 V limit) one clock later, and it holds that value between strobes.
- R3: A short-LED fault (code 1) is latched at the strobe that gives the fourth consecutive sample with `vs_below_lo` high. Any strobe sample with `vs_below_lo` low restarts the count.
- R4: A strobe with `slp_blank` high clears the consecutive count and cannot raise a short-LED fault.
- R5: `vs_ovp` high at a strobe latches code 2. `vs_ovp` without a strobe has no effect. `vdd_ovp` high on any clock latches code 3.
- R6: In current mode (`vmode` = 0), `cs_pk_low` high at the first strobe after reset or after an undervoltage clear latches code 4. At later strobes the same condition has no effect.
- R7: In voltage mode (`vmode` = 1), `cs_pk_low` and `line_hi` both high at a strobe latch code 5. With `line_hi` low the same strobe has no effect.
- R8: `cs_ocp` high on any clock latches code 6.
- R9: A latched fault holds `gate_inh` at 1 and keeps its first code until `vdd_uvlo` is high. That clock clears the latch, the code, the consecutive count, and re-arms the first-cycle check.
- R10: `temp_hot` sets an over-temperature state; `temp_cool` clears it; `temp_hot` wins when both are high. While this state is set and no fault is latched, `gate_inh` is 1 and `fault_code` is 7.
- R11: When faults arrive on the same clock, the code captured follows the priority 6 > 3 > 2 > 4 > 5 > 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | End-of-switching-cycle sample strobe |
| vs_below_lo | input | 1 | Sampled voltage-sense level below 0.3 V |
| vs_ovp | input | 1 | Sampled voltage-sense level above 3.0 V |
| vdd_ovp | input | 1 | Supply above its over-voltage level |
| cs_pk_low | input | 1 | Current-sense peak of the cycle below 0.1 V |
| cs_ocp | input | 1 | Current-sense above 1.35 V |
| line_hi | input | 1 | Line voltage above 60 % of its peak |
| vmode | input | 1 | 1 = voltage mode (after startup), 0 = current mode |
| slp_blank | input | 1 | Startup blanking of the short-LED check |
| temp_hot | input | 1 | Die temperature at or above the trip point |
| temp_cool | input | 1 | Die temperature at least 10 °C below the trip point |
| vdd_uvlo | input | 1 | Supply below turn-off level (restart) |
| gate_inh | output | 1 | 1 = stop gate switching |
| cl_low_sel | output | 1 | 1 = low current-limit level selected |
| fault_code | output | 3 | Cause of the present inhibit, 0 = none |

## Verification
A wrong consecutive count shows up at the ports as a short-LED code that appears one strobe too early or too late. It can also show up as a code that still appears after a good sample should have restarted the run. A stale first-cycle flag turns a harmless later low-peak strobe into a code 4 on the next clock, or hides a real first-cycle short. A latch or priority error shows up on the clock after the stimulus as the wrong code, as a code that changes while latched, or as an inhibit that an undervoltage clock fails to drop. Each result is therefore compared one clock after the stimulus that caused it.

// File: rtl/fault_supervisor_pkg.sv
// Shared cause codes for the fault supervisor.
package fault_supervisor_pkg;
    typedef enum logic [2:0] {
        FC_NONE    = 3'd0,
        FC_SLP     = 3'd1,
        FC_VS_OVP  = 3'd2,
        FC_VDD_OVP = 3'd3,
        FC_SRS_CM  = 3'd4,
        FC_SRS_VM  = 3'd5,
        FC_OCP     = 3'd6,
        FC_OTP     = 3'd7
    } fault_code_e;
endpackage

// File: rtl/fs_slp_qual.sv
// Short-LED qualifier: counts consecutive low voltage-sense samples and
// registers the current-limit level select. Assumes stb is one clock wide.
module fs_slp_qual #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic vs_low,
    input  logic blank,
    input  logic restart,
    output logic trip,
    output logic cl_low
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_cnt;

    // Consecutive-low counter, cleared by blanking, good sample or restart (R3, R4).
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            run_cnt <= '0;
        end else if (stb) begin
            if (blank || !vs_low)       run_cnt <= '0;
            else if (run_cnt != LAST + 1'b1) run_cnt <= run_cnt + 1'b1;
        end
    end

    // Current-limit level follows the latest sample (R2).
    always_ff @(posedge clk) begin
        if (!rst_n)   cl_low <= 1'b0;
        else if (stb) cl_low <= vs_low;
    end

    // Trip on the sample that completes the run.
    assign trip = stb && !blank && vs_low && (run_cnt == LAST);

    a_r4_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stb && blank |=> run_cnt == '0);
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(RUN_LEN));
    a_r2_cl_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> cl_low == $past(vs_low));
endmodule

// File: rtl/fs_srs_qual.sv
// Sense-resistor short qualifier for both control modes. Assumes a restart
// (undervoltage) re-arms the first-cycle check.
module fs_srs_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic pk_low,
    input  logic line_hi,
    input  logic vmode,
    input  logic restart,
    output logic trip_cm,
    output logic trip_vm
);
    logic first_cyc;

    // First-cycle flag: armed by reset or restart, dropped by the first strobe (R6).
    always_ff @(posedge clk) begin
        if (!rst_n || restart) first_cyc <= 1'b1;
        else if (stb)          first_cyc <= 1'b0;
    end

    assign trip_cm = stb && !vmode && first_cyc && pk_low;
    assign trip_vm = stb && vmode && line_hi && pk_low;

    a_r6_first_drops: assert property (@(posedge clk) disable iff (!rst_n)
        stb && !restart |=> !first_cyc);
    a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> first_cyc);
endmodule

// File: rtl/fs_otp_hyst.sv
// Over-temperature state with hysteresis given as two comparator flags.
module fs_otp_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic cool,
    output logic otp_on
);
    // Set on hot, clear on cool, hot has precedence (R10).
    always_ff @(posedge clk) begin
        if (!rst_n)    otp_on <= 1'b0;
        else if (hot)  otp_on <= 1'b1;
        else if (cool) otp_on <= 1'b0;
    end

    a_r10_hot_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> otp_on);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hot && !cool |=> $stable(otp_on));
endmodule

// File: rtl/fault_supervisor.sv
// Fault supervisor top: qualifies comparator flags, latches the first cause
// by priority, and inhibits the gate until an undervoltage restart.
// Assumes all flags are synchronous to clk.
module fault_supervisor
    import fault_supervisor_pkg::*;
#(
    parameter int SLP_RUN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_stb,
    input  logic       vs_below_lo,
    input  logic       vs_ovp,
    input  logic       vdd_ovp,
    input  logic       cs_pk_low,
    input  logic       cs_ocp,
    input  logic       line_hi,
    input  logic       vmode,
    input  logic       slp_blank,
    input  logic       temp_hot,
    input  logic       temp_cool,
    input  logic       vdd_uvlo,
    output logic       gate_inh,
    output logic       cl_low_sel,
    output logic [2:0] fault_code
);
    logic        slp_trip, srs_cm_trip, srs_vm_trip, otp_on;
    logic        latched;
    fault_code_e held_code, new_code;

    fs_slp_qual #(.RUN_LEN(SLP_RUN)) u_slp (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .vs_low(vs_below_lo),
        .blank(slp_blank), .restart(vdd_uvlo), .trip(slp_trip), .cl_low(cl_low_sel)
    );

    fs_srs_qual u_srs (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .pk_low(cs_pk_low),
        .line_hi(line_hi), .vmode(vmode), .restart(vdd_uvlo),
        .trip_cm(srs_cm_trip), .trip_vm(srs_vm_trip)
    );

    fs_otp_hyst u_otp (
        .clk(clk), .rst_n(rst_n), .hot(temp_hot), .cool(temp_cool), .otp_on(otp_on)
    );

    // Priority encode of this clock's trips (R11).
    always_comb begin
        if (cs_ocp)                 new_code = FC_OCP;
        else if (vdd_ovp)           new_code = FC_VDD_OVP;
        else if (smp_stb && vs_ovp) new_code = FC_VS_OVP;
        else if (srs_cm_trip)       new_code = FC_SRS_CM;
        else if (srs_vm_trip)       new_code = FC_SRS_VM;
        else if (slp_trip)          new_code = FC_SLP;
        else                        new_code = FC_NONE;
    end

    // Fault latch: first cause kept until undervoltage restart (R9).
    always_ff @(posedge clk) begin
        if (!rst_n || vdd_uvlo) begin
            latched   <= 1'b0;
            held_code <= FC_NONE;
        end else if (!latched && new_code != FC_NONE) begin
            latched   <= 1'b1;
            held_code <= new_code;
        end
    end

    assign gate_inh   = latched || otp_on;
    assign fault_code = latched ? held_code : (otp_on ? FC_OTP : FC_NONE);

    a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        latched && !vdd_uvlo |=> latched && $stable(fault_code));
    a_r9_uvlo_clears: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uvlo |=> !latched);
    a_r8_ocp_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ocp && !vdd_uvlo |=> gate_inh);
    a_r5_vdd_ovp_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_ovp && !vdd_uvlo |=> gate_inh);
endmodule

// File: tb/fault_supervisor_tb.sv
`timescale 1ns/1ps
module fault_supervisor_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 0, vs_below_lo = 0, vs_ovp = 0, vdd_ovp = 0, cs_pk_low = 0;
    logic cs_ocp = 0, line_hi = 0, vmode = 0, slp_blank = 0, temp_hot = 0;
    logic temp_cool = 0, vdd_uvlo = 0;
    logic gate_inh, cl_low_sel;
    logic [2:0] fault_code;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic       inh;
        logic       cl;
        logic [2:0] code;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    fault_supervisor u_dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .vs_below_lo(vs_below_lo),
        .vs_ovp(vs_ovp), .vdd_ovp(vdd_ovp), .cs_pk_low(cs_pk_low), .cs_ocp(cs_ocp),
        .line_hi(line_hi), .vmode(vmode), .slp_blank(slp_blank), .temp_hot(temp_hot),
        .temp_cool(temp_cool), .vdd_uvlo(vdd_uvlo), .gate_inh(gate_inh),
        .cl_low_sel(cl_low_sel), .fault_code(fault_code)
    );

    // Monitor: after each edge, pop one expected item and compare.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (gate_inh !== e.inh || cl_low_sel !== e.cl || fault_code !== e.code) begin
                fails++;
                $display("FAIL %s: got inh=%0b cl=%0b code=%0d, expected inh=%0b cl=%0b code=%0d",
                         e.tag, gate_inh, cl_low_sel, fault_code, e.inh, e.cl, e.code);
            end
        end
    end

    // Driver: inputs already set; push the expected result of the next edge.
    task automatic expect_next(input logic inh, input logic cl, input logic [2:0] code,
                               input string tag);
        exp_t e;
        e.inh = inh; e.cl = cl; e.code = code; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        smp_stb = 0; vs_ovp = 0; vdd_ovp = 0; cs_ocp = 0; vdd_uvlo = 0;
        temp_hot = 0; temp_cool = 0; cs_pk_low = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        expect_next(0, 0, 0, "R1 reset state");

        // R2: level select follows strobe samples and holds between them
        slp_blank = 1;
        smp_stb = 1; vs_below_lo = 1; expect_next(0, 1, 0, "R2 low sample");
        vs_below_lo = 0;               expect_next(0, 1, 0, "R2 hold between strobes");
        smp_stb = 1;                   expect_next(0, 0, 0, "R2 high sample");

        // R4: blanked low samples never trip
        vs_below_lo = 1;
        for (int i = 0; i < 5; i++) begin
            smp_stb = 1; expect_next(0, 1, 0, "R4 blanked sample");
        end

        // R3: run broken by a good sample, then four in a row
        slp_blank = 0;
        for (int i = 0; i < 3; i++) begin
            smp_stb = 1; expect_next(0, 1, 0, "R3 run before break");
        end
        vs_below_lo = 0; smp_stb = 1; expect_next(0, 0, 0, "R3 good sample restarts");
        vs_below_lo = 1;
        for (int i = 0; i < 3; i++) begin
            smp_stb = 1; expect_next(0, 1, 0, "R3 run below four");
            expect_next(0, 1, 0, "R3 idle between strobes");
        end
        smp_stb = 1; expect_next(1, 1, 1, "R3 fourth sample trips");

        // R9: first cause kept, later fault ignored, uvlo clears
        smp_stb = 1; vs_ovp = 1; vs_below_lo = 0; expect_next(1, 0, 1, "R9 first cause kept");
        vdd_uvlo = 1; expect_next(0, 0, 0, "R9 uvlo clears");

        // R6: first-cycle sense short in current mode
        smp_stb = 1; cs_pk_low = 1; expect_next(1, 0, 4, "R6 first cycle short");
        vdd_uvlo = 1; expect_next(0, 0, 0, "R9 uvlo clears srs");
        smp_stb = 1; expect_next(0, 0, 0, "R6 first good cycle");
        smp_stb = 1; cs_pk_low = 1; expect_next(0, 0, 0, "R6 later cycle ignored");

        // R7: voltage-mode short needs line above 60 %
        vmode = 1;
        smp_stb = 1; cs_pk_low = 1; line_hi = 0; expect_next(0, 0, 0, "R7 low line ignored");
        smp_stb = 1; cs_pk_low = 1; line_hi = 1; expect_next(1, 0, 5, "R7 high line trips");
        vdd_uvlo = 1; line_hi = 0; expect_next(0, 0, 0, "R9 uvlo clears vm");

        // R5: over-voltage on sense pin and supply
        vs_ovp = 1; expect_next(0, 0, 0, "R5 vs_ovp without strobe ignored");
        smp_stb = 1; vs_ovp = 1; expect_next(1, 0, 2, "R5 sense ovp");
        vdd_uvlo = 1; expect_next(0, 0, 0, "R9 uvlo clears");
        vdd_ovp = 1; expect_next(1, 0, 3, "R5 supply ovp");
        vdd_uvlo = 1; expect_next(0, 0, 0, "R9 uvlo clears");

        // R8 / R11: priority among simultaneous faults
        cs_ocp = 1; vdd_ovp = 1; smp_stb = 1; vs_ovp = 1; expect_next(1, 0, 6, "R8 R11 ocp wins");
        vdd_uvlo = 1; expect_next(0, 0, 0, "R9 uvlo clears");
        vdd_ovp = 1; smp_stb = 1; vs_ovp = 1; cs_pk_low = 1; line_hi = 1;
        expect_next(1, 0, 3, "R11 supply ovp over sense ovp");
        vdd_uvlo = 1; line_hi = 0; expect_next(0, 0, 0, "R9 uvlo clears");
        vmode = 0;

        // R10: over-temperature hysteresis
        temp_hot = 1; expect_next(1, 0, 7, "R10 hot inhibits");
        expect_next(1, 0, 7, "R10 held until cool");
        temp_hot = 1; temp_cool = 1; expect_next(1, 0, 7, "R10 hot wins");
        temp_cool = 1; expect_next(0, 0, 0, "R10 cool releases");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule